// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block makes and checks even parity for a multiplexed address/data bus. When the agent drives a phase, the block computes the parity bit over the 32-bit address/data word and the 4-bit command/byte-enable field. It presents that bit one clock later, together with an output-enable strobe. When the agent receives a phase, the block waits one clock for the parity bit that comes with it. It compares that bit with its own parity over the bus values it sampled on the previous clock.

A mismatch in a received data phase pulls the active-low data-error output low for one clock. A mismatch in a received address phase pulls the active-low system-error output low for one clock. The system-error output has its own enable in addition to the parity-response enable. An optional upper lane covers a second 32-bit word, a second 4-bit enable field and a second parity bit, and is used on wide data phases only. A sticky detection flag records every mismatch, whatever the enables are set to, and holds until an explicit clear.

Top module: `bus_parity_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it, perr_n and serr_n are 1, and par_err_flag, par_lo_out, par_hi_out, par_oe_lo and par_oe_hi are 0.
- R2: In the cycle after any cycle, par_lo_out equals the XOR of that cycle's ad_lo and cbe_lo. When wide_en was high, par_hi_out equals the XOR of ad_hi and cbe_hi. The count of ones over word, enables and parity bit is therefore even.
- R3: par_oe_lo is 1 exactly in the cycle after a cycle with drive_en high. par_oe_hi is 1 only when wide_en was also high in that cycle.
- R4: A received data phase (data_phase=1, drive_en=0) is checked on the lower lane. If par_lo_in in the following cycle differs from the XOR of that phase's ad_lo and cbe_lo, and perr_resp_en is 1, then perr_n is 0 for exactly the second cycle after the phase.
- R5: On a received data phase with wide_en=1, an upper-lane mismatch (par_hi_in against ad_hi and cbe_hi) has the same effect as R4. With wide_en=0, the upper lane is ignored and neither perr_n nor par_err_flag changes.
- R6: The enables are sampled in the cycle the parity bit arrives. With perr_resp_en=0, a failing phase leaves perr_n and serr_n at 1.
- R7: A received address phase (addr_phase=1, drive_en=0) is checked on the lower lane only. A mismatch makes serr_n 0 for exactly the second cycle after the phase, and only when serr_en and perr_resp_en are both 1. perr_n stays 1.
- R8: Phases with drive_en=1 are never checked: bad parity then causes no error output and no flag.
- R9: par_err_flag becomes 1 in the second cycle after any failing received phase, whatever the enables are. It stays 1 until a cycle with clr_flag=1 and no new failure. A new failure in the same cycle as clr_flag keeps it at 1.
- R10: Failing data phases on consecutive cycles give perr_n=0 on consecutive cycles, one per failing phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ad_lo | input | 32 | Sampled lower address/data word |
| cbe_lo | input | 4 | Sampled lower command/byte-enable field |
| ad_hi | input | 32 | Sampled upper data word |
| cbe_hi | input | 4 | Sampled upper byte-enable field |
| par_lo_in | input | 1 | Received lower parity bit, one clock late |
| par_hi_in | input | 1 | Received upper parity bit, one clock late |
| addr_phase | input | 1 | Current cycle is an address phase |
| data_phase | input | 1 | Current cycle completes a data phase |
| drive_en | input | 1 | This agent drives the word in this cycle |
| wide_en | input | 1 | Upper lane takes part in this phase |
| perr_resp_en | input | 1 | Parity-error response enable |
| serr_en | input | 1 | System-error report enable |
| clr_flag | input | 1 | Clears the sticky detection flag |
| par_lo_out | output | 1 | Generated lower parity bit |
| par_hi_out | output | 1 | Generated upper parity bit |
| par_oe_lo | output | 1 | Drive strobe for the lower parity bit |
| par_oe_hi | output | 1 | Drive strobe for the upper parity bit |
| perr_n | output | 1 | Data-phase parity error, active low |
| serr_n | output | 1 | Address-phase system error, active low |
| par_err_flag | output | 1 | Sticky parity-mismatch flag |

## Verification
A corrupted lane parity register shows up one cycle after a phase. For a driven phase it appears as a wrong par_lo_out or par_hi_out. For a received phase it appears in the cycle after that as a spurious or missing low pulse on perr_n or serr_n, together with a wrong par_err_flag. A stale phase qualifier shows at the same two-cycle point: an error lands on the wrong output, or a driven phase is reported. A flag that loses its state becomes visible on the next sample after the clear, or in the cycle in which a set and a clear meet.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
  // Qualifiers of a phase, held one clock until its parity bit arrives
  typedef struct packed {
    logic chk_addr;  // received address phase
    logic chk_data;  // received data phase
    logic chk_hi;    // received wide data phase
    logic oe_lo;     // lower parity is ours to drive
    logic oe_hi;     // upper parity is ours to drive
  } phase_q_t;

  localparam phase_q_t PHASE_IDLE = '0;
endpackage

// File: rtl/bpu_lane.sv
module bpu_lane #(
  parameter int AD_W = 32,
  parameter int BE_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AD_W-1:0] ad,
  input  logic [BE_W-1:0] cbe,
  input  logic            par_rx,
  output logic            par_gen,
  output logic            par_bad
);
  // Parity bit that makes the lane's ones count even, one clock late
  always_ff @(posedge clk) begin
    if (rst) par_gen <= 1'b0;
    else     par_gen <= ^{ad, cbe};
  end

  // Received bit must equal the bit this lane would have driven
  assign par_bad = par_gen ^ par_rx;
endmodule

// File: rtl/bpu_err_report.sv
module bpu_err_report (
  input  logic clk,
  input  logic rst,
  input  logic chk_addr,
  input  logic chk_data,
  input  logic chk_hi,
  input  logic bad_lo,
  input  logic bad_hi,
  input  logic perr_resp_en,
  input  logic serr_en,
  input  logic clr_flag,
  output logic perr_n,
  output logic serr_n,
  output logic err_flag
);
  logic data_bad, addr_bad;

  assign data_bad = chk_data & (bad_lo | (chk_hi & bad_hi));
  assign addr_bad = chk_addr & bad_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      perr_n   <= 1'b1;
      serr_n   <= 1'b1;
      err_flag <= 1'b0;
    end else begin
      perr_n <= ~(data_bad & perr_resp_en);
      serr_n <= ~(addr_bad & serr_en & perr_resp_en);
      if (data_bad | addr_bad) err_flag <= 1'b1;
      else if (clr_flag)       err_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit #(
  parameter int AD_W     = 32,
  parameter int BE_W     = 4,
  parameter bit UPPER_EN = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AD_W-1:0] ad_lo,
  input  logic [BE_W-1:0] cbe_lo,
  input  logic [AD_W-1:0] ad_hi,
  input  logic [BE_W-1:0] cbe_hi,
  input  logic            par_lo_in,
  input  logic            par_hi_in,
  input  logic            addr_phase,
  input  logic            data_phase,
  input  logic            drive_en,
  input  logic            wide_en,
  input  logic            perr_resp_en,
  input  logic            serr_en,
  input  logic            clr_flag,
  output logic            par_lo_out,
  output logic            par_hi_out,
  output logic            par_oe_lo,
  output logic            par_oe_hi,
  output logic            perr_n,
  output logic            serr_n,
  output logic            par_err_flag
);
  import bpu_pkg::*;

  localparam int LANES = UPPER_EN ? 2 : 1;

  logic [LANES-1:0][AD_W-1:0] lane_ad;
  logic [LANES-1:0][BE_W-1:0] lane_cbe;
  logic [LANES-1:0]           lane_rx, lane_gen, lane_bad;
  logic                       bad_hi;
  phase_q_t                   ph_q;

  // Phase qualifiers, aligned with the cycle the parity bit arrives
  always_ff @(posedge clk) begin
    if (rst) ph_q <= PHASE_IDLE;
    else begin
      ph_q.chk_addr <= addr_phase & ~drive_en;
      ph_q.chk_data <= data_phase & ~drive_en;
      ph_q.chk_hi   <= data_phase & ~drive_en & wide_en & UPPER_EN;
      ph_q.oe_lo    <= drive_en;
      ph_q.oe_hi    <= drive_en & wide_en & UPPER_EN;
    end
  end

  assign lane_ad[0]  = ad_lo;
  assign lane_cbe[0] = cbe_lo;
  assign lane_rx[0]  = par_lo_in;

  generate
    if (UPPER_EN) begin : g_upper
      assign lane_ad[1]  = ad_hi;
      assign lane_cbe[1] = cbe_hi;
      assign lane_rx[1]  = par_hi_in;
      assign bad_hi      = lane_bad[1];
      assign par_hi_out  = lane_gen[1];
    end else begin : g_narrow
      assign bad_hi     = 1'b0;
      assign par_hi_out = 1'b0;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
      bpu_lane #(.AD_W(AD_W), .BE_W(BE_W)) u_lane (
        .clk     (clk),
        .rst     (rst),
        .ad      (lane_ad[i]),
        .cbe     (lane_cbe[i]),
        .par_rx  (lane_rx[i]),
        .par_gen (lane_gen[i]),
        .par_bad (lane_bad[i])
      );
    end
  endgenerate

  assign par_lo_out = lane_gen[0];
  assign par_oe_lo  = ph_q.oe_lo;
  assign par_oe_hi  = ph_q.oe_hi;

  bpu_err_report u_report (
    .clk          (clk),
    .rst          (rst),
    .chk_addr     (ph_q.chk_addr),
    .chk_data     (ph_q.chk_data),
    .chk_hi       (ph_q.chk_hi),
    .bad_lo       (lane_bad[0]),
    .bad_hi       (bad_hi),
    .perr_resp_en (perr_resp_en),
    .serr_en      (serr_en),
    .clr_flag     (clr_flag),
    .perr_n       (perr_n),
    .serr_n       (serr_n),
    .err_flag     (par_err_flag)
  );
endmodule

// File: rtl/bpu_checker.sv
module bpu_checker #(
  parameter int AD_W = 32,
  parameter int BE_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [AD_W-1:0] ad_lo,
  input logic [BE_W-1:0] cbe_lo,
  input logic [AD_W-1:0] ad_hi,
  input logic [BE_W-1:0] cbe_hi,
  input logic            data_phase,
  input logic            drive_en,
  input logic            perr_resp_en,
  input logic            serr_en,
  input logic            clr_flag,
  input logic            par_lo_out,
  input logic            par_hi_out,
  input logic            par_oe_lo,
  input logic            par_oe_hi,
  input logic            perr_n,
  input logic            serr_n,
  input logic            par_err_flag
);
  AST_GEN_LO: assert property (@(posedge clk) disable iff (rst)
    par_oe_lo |-> par_lo_out == $past(^{ad_lo, cbe_lo}));  // R2
  AST_GEN_HI: assert property (@(posedge clk) disable iff (rst)
    par_oe_hi |-> par_hi_out == $past(^{ad_hi, cbe_hi}));  // R2
  AST_OE_FOLLOWS_DRIVE: assert property (@(posedge clk) disable iff (rst)
    par_oe_lo |-> $past(drive_en));  // R3
  AST_PERR_GATED: assert property (@(posedge clk) disable iff (rst)
    !perr_n |-> $past(perr_resp_en));  // R6
  AST_SERR_GATED: assert property (@(posedge clk) disable iff (rst)
    !serr_n |-> $past(serr_en && perr_resp_en));  // R7
  AST_NO_CHECK_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    !perr_n |-> $past(data_phase && !drive_en, 2));  // R8
  AST_FLAG_ON_PERR: assert property (@(posedge clk) disable iff (rst)
    !perr_n |-> par_err_flag);  // R9
  AST_FLAG_ON_SERR: assert property (@(posedge clk) disable iff (rst)
    !serr_n |-> par_err_flag);  // R9
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    par_err_flag && !clr_flag |=> par_err_flag);  // R9
endmodule

bind bus_parity_unit bpu_checker #(.AD_W(AD_W), .BE_W(BE_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ad_lo        (ad_lo),
  .cbe_lo       (cbe_lo),
  .ad_hi        (ad_hi),
  .cbe_hi       (cbe_hi),
  .data_phase   (data_phase),
  .drive_en     (drive_en),
  .perr_resp_en (perr_resp_en),
  .serr_en      (serr_en),
  .clr_flag     (clr_flag),
  .par_lo_out   (par_lo_out),
  .par_hi_out   (par_hi_out),
  .par_oe_lo    (par_oe_lo),
  .par_oe_hi    (par_oe_hi),
  .perr_n       (perr_n),
  .serr_n       (serr_n),
  .par_err_flag (par_err_flag)
);

// File: tb/bus_parity_unit_bench.sv
module bus_parity_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ad_lo = '0, ad_hi = '0;
  logic [3:0]  cbe_lo = '0, cbe_hi = '0;
  logic        par_lo_in = 1'b0, par_hi_in = 1'b0;
  logic        addr_phase = 1'b0, data_phase = 1'b0, drive_en = 1'b0, wide_en = 1'b0;
  logic        perr_resp_en = 1'b1, serr_en = 1'b1, clr_flag = 1'b0;
  logic        par_lo_out, par_hi_out, par_oe_lo, par_oe_hi, perr_n, serr_n, par_err_flag;

  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bus_parity_unit u_bus_parity_unit (
    .clk(clk), .rst(rst), .ad_lo(ad_lo), .cbe_lo(cbe_lo), .ad_hi(ad_hi), .cbe_hi(cbe_hi),
    .par_lo_in(par_lo_in), .par_hi_in(par_hi_in), .addr_phase(addr_phase),
    .data_phase(data_phase), .drive_en(drive_en), .wide_en(wide_en),
    .perr_resp_en(perr_resp_en), .serr_en(serr_en), .clr_flag(clr_flag),
    .par_lo_out(par_lo_out), .par_hi_out(par_hi_out), .par_oe_lo(par_oe_lo),
    .par_oe_hi(par_oe_hi), .perr_n(perr_n), .serr_n(serr_n), .par_err_flag(par_err_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    addr_phase = 1'b0; data_phase = 1'b0; drive_en = 1'b0; wide_en = 1'b0;
    ad_lo = '0; cbe_lo = '0; ad_hi = '0; cbe_hi = '0;
    par_lo_in = 1'b0; par_hi_in = 1'b0; clr_flag = 1'b0;
  endtask

  task automatic clear_flag();
    clr_flag = 1'b1; step(); clr_flag = 1'b0;
    chk("R9 flag cleared", par_err_flag, 0);
  endtask

  // One phase, its parity bit (optionally wrong) one clock later, error outputs two clocks later
  task automatic rx_phase(input bit a, input bit d, input bit drv, input bit w,
                          input logic [31:0] lo, input logic [3:0] clo,
                          input logic [31:0] hi, input logic [3:0] chi,
                          input bit blo, input bit bhi,
                          input bit exp_perr_low, input bit exp_serr_low, input string req);
    addr_phase = a; data_phase = d; drive_en = drv; wide_en = w;
    ad_lo = lo; cbe_lo = clo; ad_hi = hi; cbe_hi = chi;
    step();
    addr_phase = 1'b0; data_phase = 1'b0; drive_en = 1'b0; wide_en = 1'b0;
    par_lo_in = (^{lo, clo}) ^ blo;
    par_hi_in = (^{hi, chi}) ^ bhi;
    ad_lo = '0; cbe_lo = '0; ad_hi = '0; cbe_hi = '0;
    step();
    par_lo_in = 1'b0; par_hi_in = 1'b0;
    chk({req, " perr_n"}, perr_n, !exp_perr_low);
    chk({req, " serr_n"}, serr_n, !exp_serr_low);
    step();
    chk({req, " perr_n one cycle"}, perr_n, 1);
    chk({req, " serr_n one cycle"}, serr_n, 1);
  endtask

  task automatic t_reset();
    rst = 1'b1; idle_inputs();
    ad_lo = 32'hFFFF_FFFF; cbe_lo = 4'h7; drive_en = 1'b1; wide_en = 1'b1;
    step(); step();
    chk("R1 reset perr_n", perr_n, 1);
    chk("R1 reset serr_n", serr_n, 1);
    chk("R1 reset flag", par_err_flag, 0);
    chk("R1 reset par_lo_out", par_lo_out, 0);
    chk("R1 reset oe", {par_oe_lo, par_oe_hi, par_hi_out}, 0);
    idle_inputs();
    rst = 1'b0;
    step();
    chk("R1 post reset outputs", {perr_n, serr_n, par_err_flag, par_oe_lo, par_oe_hi}, 5'b11000);
  endtask

  task automatic drv_gen(input bit w, input logic [31:0] lo, input logic [3:0] clo,
                         input logic [31:0] hi, input logic [3:0] chi);
    drive_en = 1'b1; data_phase = 1'b1; wide_en = w;
    ad_lo = lo; cbe_lo = clo; ad_hi = hi; cbe_hi = chi;
    step();
    idle_inputs();
    chk("R2 par_lo_out", par_lo_out, ^{lo, clo});
    chk("R2 even ones lower", ^{lo, clo, par_lo_out}, 0);
    chk("R3 par_oe_lo", par_oe_lo, 1);
    chk("R3 par_oe_hi", par_oe_hi, w);
    if (w) chk("R2 par_hi_out", par_hi_out, ^{hi, chi});
    step();
    chk("R3 oe drops", {par_oe_lo, par_oe_hi}, 0);
    chk("R8 driven phase no flag", par_err_flag, 0);
  endtask

  task automatic t_generate();
    drv_gen(1'b0, 32'h0000_0001, 4'h0, 32'h0, 4'h0);
    drv_gen(1'b0, 32'hA5A5_0F0F, 4'hB, 32'h0, 4'h0);
    drv_gen(1'b1, 32'h1234_5678, 4'h6, 32'h8000_0003, 4'h1);
    drv_gen(1'b1, 32'hFFFF_FFFF, 4'hF, 32'h7FFF_FFFF, 4'hE);
  endtask

  task automatic t_data_lower();
    perr_resp_en = 1'b1; serr_en = 1'b1;
    rx_phase(0, 1, 0, 0, 32'hDEAD_BEEF, 4'h3, 0, 0, 0, 0, 0, 0, "R4 good data");
    chk("R9 good data no flag", par_err_flag, 0);
    rx_phase(0, 1, 0, 0, 32'hDEAD_BEEF, 4'h3, 0, 0, 1, 0, 1, 0, "R4 bad data");
    chk("R9 flag after bad data", par_err_flag, 1);
    step();
    chk("R9 flag holds", par_err_flag, 1);
    clear_flag();
  endtask

  task automatic t_upper();
    rx_phase(0, 1, 0, 1, 32'h0F0F_0000, 4'h1, 32'hCAFE_0001, 4'h9, 0, 1, 1, 0, "R5 wide upper bad");
    chk("R5 flag wide", par_err_flag, 1);
    clear_flag();
    rx_phase(0, 1, 0, 0, 32'h0F0F_0000, 4'h1, 32'hCAFE_0001, 4'h9, 0, 1, 0, 0, "R5 narrow upper ignored");
    chk("R5 narrow no flag", par_err_flag, 0);
  endtask

  task automatic t_disable();
    perr_resp_en = 1'b0;
    rx_phase(0, 1, 0, 0, 32'h0000_00FF, 4'h0, 0, 0, 1, 0, 0, 0, "R6 perr disabled");
    chk("R6 flag still set", par_err_flag, 1);
    clear_flag();
    serr_en = 1'b1;
    rx_phase(1, 0, 0, 0, 32'h1000_0000, 4'h7, 0, 0, 1, 0, 0, 0, "R6 serr needs perr_resp_en");
    chk("R9 flag on address error", par_err_flag, 1);
    clear_flag();
    perr_resp_en = 1'b1;
  endtask

  task automatic t_address();
    serr_en = 1'b1;
    rx_phase(1, 0, 0, 0, 32'h4000_0010, 4'h6, 0, 0, 1, 0, 0, 1, "R7 addr bad");
    clear_flag();
    rx_phase(1, 0, 0, 1, 32'h4000_0010, 4'h6, 32'h1, 4'h0, 0, 1, 0, 0, "R7 addr upper unused");
    chk("R7 addr upper no flag", par_err_flag, 0);
    serr_en = 1'b0;
    rx_phase(1, 0, 0, 0, 32'h4000_0010, 4'h6, 0, 0, 1, 0, 0, 0, "R7 serr disabled");
    clear_flag();
    serr_en = 1'b1;
  endtask

  task automatic t_driven();
    rx_phase(0, 1, 1, 1, 32'h5555_AAAA, 4'h5, 32'h3, 4'h3, 1, 1, 0, 0, "R8 driven data");
    rx_phase(1, 0, 1, 0, 32'h5555_AAAA, 4'h5, 0, 0, 1, 0, 0, 0, "R8 driven addr");
    chk("R8 no flag", par_err_flag, 0);
  endtask

  task automatic t_back_to_back();
    data_phase = 1'b1; ad_lo = 32'h0000_0003; cbe_lo = 4'h0;
    step();
    par_lo_in = 1'b1;  // wrong for first phase (correct is 0)
    ad_lo = 32'h0000_0007; cbe_lo = 4'h0;
    step();
    data_phase = 1'b0; ad_lo = '0;
    par_lo_in = 1'b0;  // wrong for second phase (correct is 1)
    chk("R10 first perr", perr_n, 0);
    step();
    par_lo_in = 1'b0;
    chk("R10 second perr", perr_n, 0);
    step();
    chk("R10 perr released", perr_n, 1);
    clear_flag();
  endtask

  task automatic t_clear_race();
    data_phase = 1'b1; ad_lo = 32'h1; cbe_lo = 4'h0;
    step();
    idle_inputs();
    par_lo_in = 1'b0;  // wrong: correct is 1
    clr_flag = 1'b1;
    step();
    clr_flag = 1'b0;
    chk("R9 set wins over clear", par_err_flag, 1);
    step();
    clear_flag();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  initial begin
    idle_inputs();
    step();
    t_reset();
    t_generate();
    t_data_lower();
    t_upper();
    t_disable();
    t_address();
    t_driven();
    t_back_to_back();
    t_clear_race();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      finish_run();
    end
  end
endmodule